// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multi-register load or store. One start pulse hands it a register selection mask, a base address, an addressing mode, a writeback enable and a load flag. The sequencer then offers one (register index, word address) pair per cycle on a valid/ready handshake. The selected registers always come out in ascending index order, at ascending word addresses. Once the final pair has been accepted, it raises a one-cycle done pulse. With that pulse it presents the updated base value and says whether the base should be written back.

The mode selects increment or decrement, and whether the address steps before or after each access. It sets both the first address and the writeback value. A load whose mask includes the program counter also raises a control-flow change flag along with done. The register file and the memory stay outside the block, which produces only the access order and the writeback value.

Top module: `blk_xfer_seq`

## Requirements
- R1: While reset is low, and in the cycle after it, busy_o, xfer_valid_o, done_o, wb_valid_o and pc_load_o are all low.
- R2: Every register whose mask bit is set is offered exactly once, in ascending index order. No unselected index is ever offered.
- R3: Let N be the number of set mask bits and B the base. The first address depends on mode_i: 2'b00 (increment, step after) gives B; 2'b01 (increment, step before) gives B+4; 2'b10 (decrement, step after) gives B-4N+4; 2'b11 (decrement, step before) gives B-4N. All arithmetic is modulo 2^32.
- R4: Each accepted pair that is not the last is followed by a pair whose address is 4 higher.
- R5: The sequence advances only on a cycle where xfer_valid_o and xfer_ready_i are both high. While ready is low, the index and the address hold.
- R6: xfer_last_o is high only on the final pair. done_o is high for exactly one cycle: the cycle after the final pair is accepted.
- R7: When done_o is high, wb_addr_o equals B+4N for the increment modes (mode_i bit 1 low) and B-4N for the decrement modes. wb_valid_o equals the latched writeback enable when N is nonzero.
- R8: A start with an all-zero mask produces done_o in the next cycle with no pair offered. In that cycle wb_valid_o is low and wb_addr_o equals B.
- R9: pc_load_o is high exactly in the done cycle of a load (load_i high at start) whose mask has bit 15 set.
- R10: A start pulse, or a change on the mask, base, mode or enable inputs, has no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| mask_i | input | 16 | Register selection mask |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Addressing mode (bit1 decrement, bit0 step-before) |
| wb_en_i | input | 1 | Write the updated base back |
| load_i | input | 1 | Operation is a load |
| busy_o | output | 1 | Operation in progress |
| xfer_valid_o | output | 1 | Pair on xfer_idx_o/xfer_addr_o is valid |
| xfer_ready_i | input | 1 | Consumer accepts the pair |
| xfer_idx_o | output | 4 | Register index of the current pair |
| xfer_addr_o | output | 32 | Word address of the current pair |
| xfer_last_o | output | 1 | Current pair is the final one |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Base writeback requested (with done_o) |
| wb_addr_o | output | 32 | Updated base value |
| pc_load_o | output | 1 | Program counter loaded, control flow changes (with done_o) |

## Verification
Two events can land on the same cycle. One is the acceptance of the final pair, which also clears the last bit of the remaining mask. The other is a stall or a fresh start request arriving while the block is still busy. The bench drives random ready stalls in every mode and for every mask pattern. It also pulses start, with different operands on the inputs, in the middle of a transfer. Every offered index and address is compared against values computed arithmetically from the mask, base and mode. The done cycle is judged on the writeback value, the writeback flag and the program-counter flag. The pair count and the exact cycle of done are checked as well.

// File: rtl/blk_xfer_pkg.sv
// Shared types for the block transfer sequencer.
// Assumes: mode bit 1 selects decrement, bit 0 selects step-before.
package blk_xfer_pkg;

    typedef enum logic [1:0] {
        AM_INC_AFTER  = 2'b00,
        AM_INC_BEFORE = 2'b01,
        AM_DEC_AFTER  = 2'b10,
        AM_DEC_BEFORE = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_XFER = 2'b01,
        SQ_DONE = 2'b10
    } seq_state_e;

endpackage

// File: rtl/bxs_popcount.sv
// Counts the set bits of a mask.
// Assumes: CW is wide enough to hold W.
module bxs_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    // Sum the mask bits as an adder chain.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/bxs_lowest_set.sv
// Priority encoder that returns the index of the lowest set bit.
// Assumes: idx_o is meaningless when found_o is low.
module bxs_lowest_set #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);

    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IW'(i);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bxs_span_calc.sv
// Works out the first access address and the writeback base from the
// base, the selected-register count and the addressing mode.
// Assumes: WB is a power of two; arithmetic wraps modulo 2^AW.
module bxs_span_calc
    import blk_xfer_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 5,
    parameter int WB = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  addr_mode_e    mode_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] wb_o
);

    localparam int SH = $clog2(WB);

    logic [AW-1:0] span;
    logic [AW-1:0] low_end;

    // Byte span covered by the selected registers.
    always_comb span = {{(AW - CW){1'b0}}, cnt_i} << SH;

    // Lowest address touched, before the step-before/after adjustment.
    always_comb low_end = mode_i[1] ? (base_i - span) : base_i;

    // Pick the first address and the writeback value for the mode.
    always_comb begin
        unique case (mode_i)
            AM_INC_AFTER:  first_o = low_end;
            AM_INC_BEFORE: first_o = low_end + AW'(WB);
            AM_DEC_AFTER:  first_o = low_end + AW'(WB);
            default:       first_o = low_end;
        endcase
        wb_o = mode_i[1] ? (base_i - span) : (base_i + span);
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Block transfer address sequencer: takes an operation on start_i when
// idle, offers one (index, address) pair per cycle on a valid/ready
// handshake in ascending index order, then pulses done_o with the
// writeback value. Assumes the consumer holds nothing between pairs.
module blk_xfer_seq
    import blk_xfer_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int AW     = 32,
    parameter int WB     = 4,
    parameter int PC_IDX = NREG - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [NREG-1:0]         mask_i,
    input  logic [AW-1:0]           base_i,
    input  logic [1:0]              mode_i,
    input  logic                    wb_en_i,
    input  logic                    load_i,
    output logic                    busy_o,
    output logic                    xfer_valid_o,
    input  logic                    xfer_ready_i,
    output logic [$clog2(NREG)-1:0] xfer_idx_o,
    output logic [AW-1:0]           xfer_addr_o,
    output logic                    xfer_last_o,
    output logic                    done_o,
    output logic                    wb_valid_o,
    output logic [AW-1:0]           wb_addr_o,
    output logic                    pc_load_o
);

    localparam int IW = $clog2(NREG);
    localparam int CW = $clog2(NREG + 1);

    seq_state_e      state_q;
    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_addr_q;
    logic            wb_en_q;
    logic            pc_q;

    logic [CW-1:0]   sel_cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   wb_calc;
    logic [IW-1:0]   cur_idx;
    logic            cur_found;
    logic [NREG-1:0] rem_next;
    logic            accept;
    logic            fire;

    bxs_popcount #(.W(NREG), .CW(CW)) u_pop (
        .vec_i (mask_i),
        .cnt_o (sel_cnt)
    );

    bxs_span_calc #(.AW(AW), .CW(CW), .WB(WB)) u_span (
        .base_i  (base_i),
        .cnt_i   (sel_cnt),
        .mode_i  (addr_mode_e'(mode_i)),
        .first_o (first_addr),
        .wb_o    (wb_calc)
    );

    bxs_lowest_set #(.W(NREG), .IW(IW)) u_pick (
        .vec_i   (rem_q),
        .idx_o   (cur_idx),
        .found_o (cur_found)
    );

    // Start is taken only when idle; a pair fires on valid and ready.
    always_comb begin
        accept   = start_i && (state_q == SQ_IDLE);
        fire     = xfer_valid_o && xfer_ready_i;
        rem_next = rem_q & ~(NREG'(1) << cur_idx);
    end

    // Sequencer state and latched operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            rem_q     <= '0;
            addr_q    <= '0;
            wb_addr_q <= '0;
            wb_en_q   <= 1'b0;
            pc_q      <= 1'b0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        rem_q     <= mask_i;
                        addr_q    <= first_addr;
                        wb_addr_q <= wb_calc;
                        wb_en_q   <= wb_en_i && (|mask_i);
                        pc_q      <= load_i && mask_i[PC_IDX];
                        state_q   <= (|mask_i) ? SQ_XFER : SQ_DONE;
                    end
                end
                SQ_XFER: begin
                    if (fire) begin
                        rem_q  <= rem_next;
                        addr_q <= addr_q + AW'(WB);
                        if (rem_next == '0) begin
                            state_q <= SQ_DONE;
                        end
                    end
                end
                default: begin
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    // Output decode from state and registers.
    always_comb begin
        busy_o       = (state_q != SQ_IDLE);
        xfer_valid_o = (state_q == SQ_XFER) && cur_found;
        xfer_idx_o   = cur_idx;
        xfer_addr_o  = addr_q;
        xfer_last_o  = xfer_valid_o && (rem_next == '0);
        done_o       = (state_q == SQ_DONE);
        wb_valid_o   = done_o && wb_en_q;
        wb_addr_o    = wb_addr_q;
        pc_load_o    = done_o && pc_q;
    end

endmodule

// File: rtl/bxs_checker.sv
// Property checker for blk_xfer_seq, attached by bind below.
// Assumes: reset is synchronous and active low.
module bxs_checker #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int WB   = 4,
    parameter int IW   = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [NREG-1:0] mask_i,
    input logic            busy_o,
    input logic            xfer_valid_o,
    input logic            xfer_ready_i,
    input logic [IW-1:0]   xfer_idx_o,
    input logic [AW-1:0]   xfer_addr_o,
    input logic            xfer_last_o,
    input logic            done_o,
    input logic            wb_valid_o,
    input logic            pc_load_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !busy_o && !xfer_valid_o && !done_o && !wb_valid_o && !pc_load_o);

    // R2
    idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && !xfer_last_o |=> xfer_idx_o > $past(xfer_idx_o));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && !xfer_last_o
        |=> xfer_valid_o && (xfer_addr_o == $past(xfer_addr_o) + AW'(WB)));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && !xfer_ready_i
        |=> xfer_valid_o && $stable(xfer_idx_o) && $stable(xfer_addr_o));

    // R6
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && xfer_ready_i && xfer_last_o |=> done_o && !xfer_valid_o);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> done_o);

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && (mask_i == '0) |=> done_o && !xfer_valid_o && !wb_valid_o);

    // R9
    pc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> done_o);

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && xfer_valid_o && !(xfer_ready_i && xfer_last_o) |=> xfer_valid_o && !done_o);

endmodule

bind blk_xfer_seq bxs_checker #(.NREG(NREG), .AW(AW), .WB(WB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mask_i       (mask_i),
    .busy_o       (busy_o),
    .xfer_valid_o (xfer_valid_o),
    .xfer_ready_i (xfer_ready_i),
    .xfer_idx_o   (xfer_idx_o),
    .xfer_addr_o  (xfer_addr_o),
    .xfer_last_o  (xfer_last_o),
    .done_o       (done_o),
    .wb_valid_o   (wb_valid_o),
    .pc_load_o    (pc_load_o)
);

// File: tb/sim_blk_xfer_seq.sv
// Sweep bench: every mode against a set of masks, with and without ready
// stalls, checking each pair and the done cycle against arithmetic.
module sim_blk_xfer_seq;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        load_i = 1'b0;
    logic        xfer_ready_i = 1'b0;
    logic        busy_o, xfer_valid_o, xfer_last_o, done_o, wb_valid_o, pc_load_o;
    logic [3:0]  xfer_idx_o;
    logic [31:0] xfer_addr_o, wb_addr_o;

    int errors = 0;
    int checks = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(PERIOD / 2) clk = ~clk;

    blk_xfer_seq u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mask_i       (mask_i),
        .base_i       (base_i),
        .mode_i       (mode_i),
        .wb_en_i      (wb_en_i),
        .load_i       (load_i),
        .busy_o       (busy_o),
        .xfer_valid_o (xfer_valid_o),
        .xfer_ready_i (xfer_ready_i),
        .xfer_idx_o   (xfer_idx_o),
        .xfer_addr_o  (xfer_addr_o),
        .xfer_last_o  (xfer_last_o),
        .done_o       (done_o),
        .wb_valid_o   (wb_valid_o),
        .wb_addr_o    (wb_addr_o),
        .pc_load_o    (pc_load_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                          input logic wb, input logic ld, input logic stall, input logic poke);
        int n = 0;
        int j = 0;
        int cnt = 0;
        int e;
        bit seen_done = 0;
        logic [31:0] exp_addr, wbv;
        logic rdy;
        for (int i = 0; i < 16; i++) n += m[i];
        case (md)
            2'b00:   exp_addr = b;
            2'b01:   exp_addr = b + 32'd4;
            2'b10:   exp_addr = b - 32'(4 * n) + 32'd4;
            default: exp_addr = b - 32'(4 * n);
        endcase
        wbv = md[1] ? (b - 32'(4 * n)) : (b + 32'(4 * n));
        @(negedge clk);
        start_i = 1'b1; mask_i = m; base_i = b; mode_i = md; wb_en_i = wb; load_i = ld;
        xfer_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; mask_i = ~m; base_i = b ^ 32'h5A5A_0F0F; mode_i = ~md; wb_en_i = ~wb;
        load_i = ~ld;
        for (int cyc = 0; cyc < 200; cyc++) begin
            if (done_o) begin
                seen_done = 1;
                // R8: empty mask completes the cycle after start
                if (n == 0) check(cyc == 0, "R8 empty done cycle", 32'(cyc), 32'd0);
                break;
            end
            if (xfer_valid_o) begin
                e = j;
                while (e < 16 && !m[e]) e++;
                // R2: next selected index in ascending order
                check(cnt < n && 32'(xfer_idx_o) == 32'(e), "R2 index order", 32'(xfer_idx_o), 32'(e));
                if (cnt == 0) check(xfer_addr_o == exp_addr, "R3 first address", xfer_addr_o, exp_addr);
                else check(xfer_addr_o == exp_addr, "R4 address step / R5 hold", xfer_addr_o, exp_addr);
                // R6: last flag only on the final pair
                check(xfer_last_o == (cnt == n - 1), "R6 last flag", 32'(xfer_last_o), 32'(cnt == n - 1));
                rdy = stall ? step_lfsr() : 1'b1;
                // R10: start pulse with other operands while busy
                if (poke && cnt == 1) start_i = 1'b1;
                xfer_ready_i = rdy;
                if (rdy) begin
                    cnt++;
                    exp_addr += 32'd4;
                    j = e + 1;
                end
            end else begin
                check(0, (cnt == n) ? "R6 done after last" : "R5 valid dropped", 32'(cnt), 32'(n));
                break;
            end
            @(negedge clk);
            start_i = 1'b0;
            xfer_ready_i = 1'b0;
        end
        check(seen_done, "R6 done seen", 32'(seen_done), 32'd1);
        if (seen_done) begin
            check(cnt == n, "R2 pair count", 32'(cnt), 32'(n));
            check(wb_valid_o == (wb && n != 0), "R7 wb_valid", 32'(wb_valid_o), 32'(wb && n != 0));
            if (n == 0) check(wb_addr_o == b, "R8 base unchanged", wb_addr_o, b);
            else check(wb_addr_o == wbv, "R7 writeback value", wb_addr_o, wbv);
            check(pc_load_o == (ld && m[15]), "R9 pc flag", 32'(pc_load_o), 32'(ld && m[15]));
            @(negedge clk);
            check(!done_o && !busy_o, "R6 single done", 32'(done_o), 32'd0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] pats [8];
        pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h8001; pats[3] = 16'hA5A5;
        pats[4] = 16'h7FFE; pats[5] = 16'h1248; pats[6] = 16'h8000; pats[7] = 16'h0C30;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_o && !xfer_valid_o && !done_o && !wb_valid_o && !pc_load_o,
              "R1 reset outputs", {27'd0, busy_o, xfer_valid_o, done_o, wb_valid_o, pc_load_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 idle after reset", {30'd0, busy_o, done_o}, 32'd0);
        for (int md = 0; md < 4; md++) begin
            for (int st = 0; st < 2; st++) begin
                for (int p = 0; p < 8; p++)
                    run_op(pats[p], 32'h0000_1000 + 32'(p * 64), 2'(md), p[0], p[1], st[0], 1'b1);
                for (int s = 0; s < 16; s++)
                    run_op(16'(1) << s, 32'h0000_0010, 2'(md), 1'b1, 1'b1, st[0], 1'b0);
                for (int r = 0; r < 6; r++) begin
                    logic [15:0] rm;
                    rm = {lfsr[7:0], lfsr[15:8]} ^ 16'(r * 16'h3C71);
                    void'(step_lfsr());
                    run_op(rm, 32'h0000_0004, 2'(md), 1'b1, r[0], st[0], 1'b1);
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule